// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out the level that each pin of a 16-pin general-purpose port presents to software. It combines the configuration of each pin with the output data and with external drivers applied to the pin. The configuration covers the mode, the output type and the pull resistor. For every pin it keeps two pieces of state: whether an external driver is attached, and the level that driver applies. A pin with no driver, no output drive and no pull is floating, and it keeps the value it last held.

External drivers are attached through a drive request stream, which carries a pin index, a level and a valid/ready pair. They are detached through a disconnect mask, or automatically when a reconfiguration puts a driven pin in conflict with an output. A transfer happens on any clock edge where `drv_valid` and `drv_ready` are both high. `drv_ready` is held low during reset and is high in every cycle after it, so the block never applies back-pressure. A transfer is accepted or refused, but it is never stalled. Each refusal sets a sticky flag and records the pin index.

Resolution is registered. `in_data` shows the result of the inputs sampled at the previous edge. One-cycle rise and fall pulses mark the cycles in which a bit of `in_data` changes.

Top module: `gpio_level_resolver`

## Requirements
- R1: A pin whose mode code is 2'b01 (output) and whose output-type bit is 0 (push-pull) reads its `out_data` bit.
- R2: A pin in output mode with output-type bit 1 (open-drain) reads 0 when its `out_data` bit is 0. When its `out_data` bit is 1 it reads 0 if an attached driver holds it low. Otherwise it reads 1 with pull code 2'b01 (up), reads 0 with pull code 2'b10 (down), and keeps its previous value with any other pull code.
- R3: A pin whose mode code is 00, 10 or 11 reads the level of its attached driver. With no driver attached it reads 1 with pull up, 0 with pull down, and keeps its previous value otherwise.
- R4: A floating pin holds the last value it had on `in_data`.
- R5: A drive request for an output-mode pin is refused unless that pin is open-drain and the requested level is 0. A refusal sets `rej_flag` (sticky until reset), loads `rej_pin` with the requested index, and leaves the pin's driver state unchanged.
- R6: In a cycle where `cfg_changed` is high, every attached pin that the current configuration puts in output mode and that is push-pull or driven high is detached. This check is made after that cycle's drive request and disconnect mask have been applied.
- R7: When `disc_valid` is high, every pin set in `disc_mask` is detached. This takes priority over an accepted drive request to the same pin in the same cycle.
- R8: Reset detaches all pins, clears all driver levels, clears `rej_flag`, and holds `in_data` at 0. In the first cycle after reset, `in_data` shows the freshly resolved levels.
- R9: Inputs sampled at a clock edge show up on `in_data` after that same edge.
- R10: `pin_rise` (`pin_fall`) is high for one cycle on exactly those bits where `in_data` went from 0 to 1 (1 to 0) at the last edge. Both are 0 when `in_data` is unchanged.
- R11: `drv_ready` is 0 during reset and 1 in every cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 32 | Two-bit mode code per pin; 2'b01 selects output |
| cfg_otype | input | 16 | Output type per pin; 1 selects open-drain |
| cfg_pull | input | 32 | Two-bit pull code per pin; 01 up, 10 down |
| out_data | input | 16 | Output data bits |
| cfg_changed | input | 1 | Strobe: mode or output type was rewritten |
| drv_valid | input | 1 | Drive request valid |
| drv_ready | output | 1 | Drive request ready |
| drv_pin | input | 4 | Pin index of drive request |
| drv_level | input | 1 | Level requested by the driver |
| disc_valid | input | 1 | Apply disconnect mask |
| disc_mask | input | 16 | Pins to detach |
| in_data | output | 16 | Resolved pin levels |
| pin_rise | output | 16 | One-cycle rising-change pulses |
| pin_fall | output | 16 | One-cycle falling-change pulses |
| rej_flag | output | 1 | Sticky: a drive request was refused |
| rej_pin | output | 4 | Index of the latest refused request |

## Verification
The hardest case to reach from the ports is the automatic detach on reconfiguration. The detach itself changes nothing that can be seen directly, because the pin it affects is now an output and reads its output drive. The stimulus first attaches a driver to a pin while the pin is an input. It then turns the pin into an output and pulses `cfg_changed`. Finally it returns the pin to input mode without a strobe, either with no pull or with the opposite pull. The value the pin then reads shows whether the driver survived the reconfiguration. Same-cycle races between a drive request and the disconnect mask are also driven on purpose, on a floating pin, to show which of the two wins.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam logic [1:0] MODE_OUT = 2'b01;
  localparam logic [1:0] PULL_UP  = 2'b01;
  localparam logic [1:0] PULL_DN  = 2'b10;
endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_res_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       open_drain,
  input  logic [1:0] pull,
  input  logic       odr_bit,
  input  logic       attached,
  input  logic       ext_high,
  input  logic       prev,
  output logic       level
);
  logic is_out;
  assign is_out = (mode == MODE_OUT);

  always_comb begin
    level = prev;
    if (is_out) begin
      if (!open_drain)                level = odr_bit;
      else if (!odr_bit)              level = 1'b0;
      else if (attached && !ext_high) level = 1'b0;
      else if (pull == PULL_UP)       level = 1'b1;
      else if (pull == PULL_DN)       level = 1'b0;
    end else if (attached) begin
      level = ext_high;
    end else if (pull == PULL_UP) begin
      level = 1'b1;
    end else if (pull == PULL_DN) begin
      level = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_ext_tracker.sv
module gpio_ext_tracker
  import gpio_res_pkg::*;
#(
  parameter int PINS = 16,
  localparam int IW = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*PINS-1:0] mode,
  input  logic [PINS-1:0]   otype,
  input  logic              cfg_changed,
  input  logic              drv_fire,
  input  logic [IW-1:0]     drv_pin,
  input  logic              drv_level,
  input  logic              disc_valid,
  input  logic [PINS-1:0]   disc_mask,
  output logic [PINS-1:0]   detached_nx,
  output logic [PINS-1:0]   high_nx,
  output logic              rej_flag,
  output logic [IW-1:0]     rej_pin
);
  logic [PINS-1:0] detached_q, high_q;
  logic            refuse;
  logic            tgt_out;

  always_comb begin
    detached_nx = detached_q;
    high_nx     = high_q;
    refuse      = 1'b0;
    tgt_out     = (mode[{drv_pin, 1'b0} +: 2] == MODE_OUT);
    if (drv_fire) begin
      if (tgt_out && !(otype[drv_pin] && !drv_level)) begin
        refuse = 1'b1;
      end else begin
        detached_nx[drv_pin] = 1'b0;
        high_nx[drv_pin]     = drv_level;
      end
    end
    if (disc_valid) detached_nx = detached_nx | disc_mask;
    if (cfg_changed) begin
      for (int i = 0; i < PINS; i++) begin
        if (!detached_nx[i] && (mode[2*i +: 2] == MODE_OUT) &&
            (!otype[i] || high_nx[i]))
          detached_nx[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      detached_q <= '1;
      high_q     <= '0;
      rej_flag   <= 1'b0;
      rej_pin    <= '0;
    end else begin
      detached_q <= detached_nx;
      high_q     <= high_nx;
      if (refuse) begin
        rej_flag <= 1'b1;
        rej_pin  <= drv_pin;
      end
    end
  end
endmodule

// File: rtl/gpio_level_resolver.sv
module gpio_level_resolver
  import gpio_res_pkg::*;
#(
  parameter int PINS = 16,
  localparam int IW = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*PINS-1:0] cfg_mode,
  input  logic [PINS-1:0]   cfg_otype,
  input  logic [2*PINS-1:0] cfg_pull,
  input  logic [PINS-1:0]   out_data,
  input  logic              cfg_changed,
  input  logic              drv_valid,
  output logic              drv_ready,
  input  logic [IW-1:0]     drv_pin,
  input  logic              drv_level,
  input  logic              disc_valid,
  input  logic [PINS-1:0]   disc_mask,
  output logic [PINS-1:0]   in_data,
  output logic [PINS-1:0]   pin_rise,
  output logic [PINS-1:0]   pin_fall,
  output logic              rej_flag,
  output logic [IW-1:0]     rej_pin
);
  logic [PINS-1:0] detached_nx, high_nx, resolved;
  logic            ready_q;

  gpio_ext_tracker #(.PINS(PINS)) u_track (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .otype(cfg_otype),
    .cfg_changed(cfg_changed), .drv_fire(drv_valid && ready_q),
    .drv_pin(drv_pin), .drv_level(drv_level), .disc_valid(disc_valid),
    .disc_mask(disc_mask), .detached_nx(detached_nx), .high_nx(high_nx),
    .rej_flag(rej_flag), .rej_pin(rej_pin)
  );

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    gpio_pin_resolve u_res (
      .mode(cfg_mode[2*g +: 2]), .open_drain(cfg_otype[g]),
      .pull(cfg_pull[2*g +: 2]), .odr_bit(out_data[g]),
      .attached(!detached_nx[g]), .ext_high(high_nx[g]),
      .prev(in_data[g]), .level(resolved[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data  <= '0;
      pin_rise <= '0;
      pin_fall <= '0;
      ready_q  <= 1'b0;
    end else begin
      in_data  <= resolved;
      pin_rise <= resolved & ~in_data;
      pin_fall <= ~resolved & in_data;
      ready_q  <= 1'b1;
    end
  end

  assign drv_ready = ready_q;
endmodule

// File: rtl/gpio_level_resolver_checker.sv
module gpio_level_resolver_checker
  import gpio_res_pkg::*;
#(
  parameter int PINS = 16,
  localparam int IW = $clog2(PINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*PINS-1:0] cfg_mode,
  input logic [PINS-1:0]   cfg_otype,
  input logic [PINS-1:0]   out_data,
  input logic              drv_valid,
  input logic              drv_ready,
  input logic [IW-1:0]     drv_pin,
  input logic [PINS-1:0]   in_data,
  input logic [PINS-1:0]   pin_rise,
  input logic              rej_flag,
  input logic [IW-1:0]     rej_pin
);
  logic [PINS-1:0] pp_mask, od_low_mask;
  logic            hit_pp;

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      pp_mask[i]     = (cfg_mode[2*i +: 2] == MODE_OUT) && !cfg_otype[i];
      od_low_mask[i] = (cfg_mode[2*i +: 2] == MODE_OUT) && cfg_otype[i] && !out_data[i];
    end
    hit_pp = drv_valid && drv_ready && pp_mask[drv_pin];
  end

  a_r1_pushpull_reads_odr: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((in_data ^ $past(out_data)) & $past(pp_mask)) == '0);

  a_r2_opendrain_low: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (in_data & $past(od_low_mask)) == '0);

  a_r5_refuse_pushpull: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pp |=> rej_flag && (rej_pin == $past(drv_pin)));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rej_flag |=> rej_flag);

  a_r10_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_rise == (in_data & ~$past(in_data)));

  a_r11_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drv_ready);
endmodule

bind gpio_level_resolver gpio_level_resolver_checker #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_otype(cfg_otype),
  .out_data(out_data), .drv_valid(drv_valid), .drv_ready(drv_ready),
  .drv_pin(drv_pin), .in_data(in_data), .pin_rise(pin_rise),
  .rej_flag(rej_flag), .rej_pin(rej_pin)
);

// File: tb/test_gpio_level_resolver.sv
`timescale 1ns/1ps
module test_gpio_level_resolver;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*N-1:0] cfg_mode = '0, cfg_pull = '0;
  logic [N-1:0]  cfg_otype = '0, out_data = '0, disc_mask = '0;
  logic          cfg_changed = 1'b0, drv_valid = 1'b0, drv_level = 1'b0, disc_valid = 1'b0;
  logic [3:0]    drv_pin = '0;
  logic          drv_ready, rej_flag;
  logic [3:0]    rej_pin;
  logic [N-1:0]  in_data, pin_rise, pin_fall;

  always #4 clk = ~clk;

  gpio_level_resolver i_gpio_level_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_otype(cfg_otype),
    .cfg_pull(cfg_pull), .out_data(out_data), .cfg_changed(cfg_changed),
    .drv_valid(drv_valid), .drv_ready(drv_ready), .drv_pin(drv_pin),
    .drv_level(drv_level), .disc_valid(disc_valid), .disc_mask(disc_mask),
    .in_data(in_data), .pin_rise(pin_rise), .pin_fall(pin_fall),
    .rej_flag(rej_flag), .rej_pin(rej_pin)
  );

  typedef struct {
    int          due;
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic compare(input int sel, input logic [15:0] exp, input string tag);
    logic [15:0] act;
    case (sel)
      0: act = in_data;
      1: act = pin_rise;
      2: act = pin_fall;
      3: act = {15'd0, rej_flag};
      4: act = {12'd0, rej_pin};
      default: act = {15'd0, drv_ready};
    endcase
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      compare(it.sel, it.exp, it.tag);
    end
  end

  task automatic expect_next(input int sel, input logic [15:0] exp, input string tag);
    item_t it;
    it.due = cyc + 1; it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    drv_valid = 1'b0; disc_valid = 1'b0; cfg_changed = 1'b0;
  endtask

  task automatic drive(input int pin, input logic lvl);
    drv_valid = 1'b1; drv_pin = 4'(pin); drv_level = lvl;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(0, 16'h0000, "R8 in_data held in reset");
    compare(5, 16'h0000, "R11 ready low in reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare(0, 16'h0000, "R8 reset state in_data");
    compare(3, 16'h0000, "R8 rej_flag clear");
    compare(5, 16'h0001, "R11 ready high");

    // R3 pulls on input pins, R10 rise pulse
    cfg_pull[1:0] = 2'b01; cfg_pull[3:2] = 2'b10;
    expect_next(0, 16'h0001, "R3 pull up/down"); expect_next(1, 16'h0001, "R10 rise");
    tick();
    cfg_pull[1:0] = 2'b00;
    expect_next(0, 16'h0001, "R4 floating holds"); expect_next(1, 16'h0000, "R10 no pulse");
    tick();
    drive(2, 1'b1);
    expect_next(0, 16'h0005, "R3 driver high R9"); tick();
    drive(2, 1'b0);
    expect_next(0, 16'h0001, "R3 driver low"); expect_next(2, 16'h0004, "R10 fall");
    tick();

    // R1 push-pull, R5 refusal
    cfg_mode[7:6] = 2'b01; out_data[3] = 1'b1;
    expect_next(0, 16'h0009, "R1 push-pull"); tick();
    drive(3, 1'b1);
    expect_next(0, 16'h0009, "R5 refused no effect");
    expect_next(3, 16'h0001, "R5 flag"); expect_next(4, 16'h0003, "R5 pin 3");
    tick();

    // R2 open-drain
    cfg_mode[9:8] = 2'b01; cfg_otype[4] = 1'b1; out_data[4] = 1'b1; cfg_pull[9:8] = 2'b01;
    expect_next(0, 16'h0019, "R2 od pull up"); tick();
    drive(4, 1'b0);
    expect_next(0, 16'h0009, "R2 od driven low"); expect_next(4, 16'h0003, "R5 accepted keeps pin");
    tick();
    drive(4, 1'b1);
    expect_next(0, 16'h0009, "R5 od high refused"); expect_next(4, 16'h0004, "R5 pin 4");
    tick();

    // R6 auto detach on reconfiguration
    drive(5, 1'b1);
    expect_next(0, 16'h0029, "R3 pin5 driven"); tick();
    cfg_mode[11:10] = 2'b01; cfg_otype[5] = 1'b1; out_data[5] = 1'b0; cfg_changed = 1'b1;
    expect_next(0, 16'h0009, "R2 od data low"); tick();
    cfg_mode[11:10] = 2'b00; cfg_otype[5] = 1'b0;
    expect_next(0, 16'h0009, "R6 driven-high od detached"); tick();
    cfg_mode[5:4] = 2'b01; out_data[2] = 1'b0; cfg_changed = 1'b1;
    expect_next(0, 16'h0009, "R1 pin2 push-pull"); tick();
    cfg_mode[5:4] = 2'b00; cfg_pull[5:4] = 2'b01;
    expect_next(0, 16'h000D, "R6 push-pull detached"); tick();

    // R7 disconnect mask
    drive(6, 1'b1);
    expect_next(0, 16'h004D, "R3 pin6 driven"); tick();
    disc_valid = 1'b1; disc_mask = 16'h0040; cfg_pull[13:12] = 2'b10;
    expect_next(0, 16'h000D, "R7 mask detaches"); expect_next(2, 16'h0040, "R10 fall pin6");
    tick();
    drive(7, 1'b1); disc_valid = 1'b1; disc_mask = 16'h0080;
    expect_next(0, 16'h000D, "R7 mask beats drive"); tick();
    disc_valid = 1'b1; disc_mask = 16'h0010;
    expect_next(0, 16'h001D, "R2 od detached pull up"); tick();
    cfg_pull[9:8] = 2'b10;
    expect_next(0, 16'h000D, "R2 od pull down"); tick();
    expect_next(3, 16'h0001, "R5 flag sticky"); tick();

    repeat (2) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule